// File: doc/BRIEF.md
# Region-Dependent Bus Cycle Timer

This block times the bus cycles of a processor in units of a fast master clock. The processor offers one bus cycle at a time. Each offer carries a 24-bit address, a flag that marks a cycle with no memory access, and an optional byte write. The block looks at the bank and page of the address and chooses a cycle length of 6, 8 or 12 master clocks. At the end of the cycle it raises a one-clock completion pulse.

The upper program-memory area can run at the fast 6-clock rate or the normal 8-clock rate. A byte write to the speed register at offset `$420D`, in any bank from `$00-$3F` or `$80-$BF`, selects the rate through bit 0 of the data. The new rate applies from the next bus cycle onward.

A free-running position counter divides master clocks into scanlines of 1364 clocks. Once per line, from a parameter position near the middle of the line, the block withholds 40 clocks from the processor for memory refresh. During that window a cycle in flight makes no progress, so its completion moves later by every withheld clock.

Top module: `bus_cycle_timer`

## Requirements
- R1: A cycle offered with `req_internal` high lasts 6 clocks whatever its address.
- R2: Pages `$40` and `$41` of banks `$00-$3F` and `$80-$BF` last 12 clocks.
- R3: Pages `$20-$3F` and `$42-$5F` of banks `$00-$3F` and `$80-$BF` last 6 clocks.
- R4: Pages `$00-$1F` and `$60-$7F` of banks `$00-$3F` and `$80-$BF`, pages `$80-$FF` of banks `$00-$3F`, and every page of banks `$40-$7F` last 8 clocks.
- R5: Pages `$80-$FF` of banks `$80-$BF` and all of banks `$C0-$FF` last 6 clocks when the speed bit is 1 and 8 clocks when it is 0. Reset clears the bit.
- R6: A write cycle to address offset `$420D` in a bank of `$00-$3F` or `$80-$BF` loads the speed bit from `req_wdata[0]` for the cycles that follow. Writes to any other address leave the bit unchanged.
- R7: An offer is accepted on a rising edge where `req_valid` and `req_ready` are both high. With no refresh, `cyc_done` is high for exactly one clock, starting N edges after acceptance for a cycle of length N. `req_ready` is high again in that same clock.
- R8: The line position counts 0 to 1363 and wraps to 0. `line_start` is high while the position is 0, so the line period is 1364 clocks.
- R9: `refresh_stall` is high for 40 consecutive clocks per line, starting at position `REFRESH_START` (default 536). That leaves 1324 clocks for the processor.
- R10: Each clock with `refresh_stall` high delays the completion of a cycle in flight by one clock. A 12-clock cycle accepted three positions before the window opens completes after 52 clocks.
- R11: During and just after reset, `req_ready` is 1, `cyc_done` is 0 and `refresh_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A bus cycle is offered |
| req_addr | input | 24 | Bank (bits 23:16), page (15:8), offset |
| req_internal | input | 1 | Cycle with no memory access |
| req_write | input | 1 | The cycle is a write |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Idle, can accept an offer |
| cyc_done | output | 1 | One-clock pulse at the end of a bus cycle |
| refresh_stall | output | 1 | Refresh window active, processor held |
| line_start | output | 1 | Line position is 0 |

## Verification
Two functions can fall in the same clock: the countdown of a bus cycle in flight, and the refresh window that freezes it. The bench keeps its own line position, counted from reset release. It starts a 12-clock access three positions before the window so that the window covers the access, and requires a total of 52 clocks with 40 of them stalled. In the random traffic, each cycle's duration minus the stalled clocks the bench counted must equal the length from the bench's own address map. This holds whether the overlap is partial, complete or absent.

// File: rtl/bct_pkg.sv
package bct_pkg;
    localparam int ADDR_W        = 24;
    localparam int LEN_W         = 4;
    localparam int BYTE_W        = 8;
    localparam logic [15:0] SPEED_REG_OFS = 16'h420D;

    typedef enum logic [2:0] {
        RGN_INTERNAL,
        RGN_REGISTER,
        RGN_SLOW,
        RGN_NORMAL,
        RGN_ROM_HI
    } region_e;
endpackage

// File: rtl/bct_region_decode.sv
module bct_region_decode
    import bct_pkg::*;
#(
    parameter int FAST_LEN   = 6,
    parameter int NORMAL_LEN = 8,
    parameter int SLOW_LEN   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              internal,
    input  logic              fast_en,
    output logic [LEN_W-1:0]  len,
    output logic              speed_reg_hit
);
    logic [7:0] bank;
    logic [7:0] page;
    region_e    region;

    assign bank = addr[23:16];
    assign page = addr[15:8];

    always_comb begin
        region = RGN_NORMAL;
        if (internal) begin
            region = RGN_INTERNAL;
        end else if (bank[6] || page[7]) begin
            // banks 40-7F/C0-FF, or upper half of a system bank
            region = bank[7] ? RGN_ROM_HI : RGN_NORMAL;
        end else if (page < 8'h20) begin
            region = RGN_NORMAL;
        end else if (page == 8'h40 || page == 8'h41) begin
            region = RGN_SLOW;
        end else if (page < 8'h60) begin
            region = RGN_REGISTER;
        end else begin
            region = RGN_NORMAL;
        end
    end

    always_comb begin
        unique case (region)
            RGN_INTERNAL, RGN_REGISTER: len = LEN_W'(FAST_LEN);
            RGN_SLOW:                   len = LEN_W'(SLOW_LEN);
            RGN_ROM_HI:                 len = fast_en ? LEN_W'(FAST_LEN) : LEN_W'(NORMAL_LEN);
            default:                    len = LEN_W'(NORMAL_LEN);
        endcase
    end

    assign speed_reg_hit = !bank[6] && (addr[15:0] == SPEED_REG_OFS);
endmodule

// File: rtl/bct_line_timer.sv
module bct_line_timer #(
    parameter int LINE_CLKS     = 1364,
    parameter int REFRESH_START = 536,
    parameter int REFRESH_CLKS  = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic stall,
    output logic line_start
);
    localparam int POS_W = $clog2(LINE_CLKS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_CLKS - 1);
    localparam logic [POS_W-1:0] WIN_LO   = POS_W'(REFRESH_START);
    localparam logic [POS_W-1:0] WIN_HI   = POS_W'(REFRESH_START + REFRESH_CLKS);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             stall;
    } lt_state_t;

    lt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pos   = (s_q.pos == POS_LAST) ? '0 : s_q.pos + 1'b1;
        s_d.stall = (s_d.pos >= WIN_LO) && (s_d.pos < WIN_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stall      = s_q.stall;
    assign line_start = (s_q.pos == '0);

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos == POS_LAST |=> s_q.pos == '0); // R8
    AST_REFRESH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stall) |-> s_q.pos == WIN_LO); // R9
    AST_REFRESH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.stall) |-> s_q.pos == WIN_HI); // R9
endmodule

// File: rtl/bct_cycle_engine.sv
module bct_cycle_engine
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_internal,
    input  logic             req_write,
    input  logic             wdata_bit,
    input  logic             speed_reg_hit,
    input  logic [LEN_W-1:0] len,
    input  logic             stall,
    output logic             ready,
    output logic             done,
    output logic             fast_en
);
    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
        logic             done;
        logic             fast;
    } eng_state_t;

    eng_state_t s_d, s_q;
    logic       accept;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = req_valid && !s_q.busy;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.cnt  = len;
            if (req_write && speed_reg_hit) s_d.fast = wdata_bit;
        end else if (s_q.busy && !stall) begin
            if (s_q.cnt == LEN_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready   = !s_q.busy;
    assign done    = s_q.done;
    assign fast_en = s_q.fast;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy); // R7
    AST_INTERNAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_internal |-> len == LEN_W'(6)); // R1
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (len == LEN_W'(6) || len == LEN_W'(8) || len == LEN_W'(12))); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && stall |=> $stable(s_q.cnt) && s_q.busy); // R10
    AST_SPEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && speed_reg_hit |=> s_q.fast == $past(wdata_bit)); // R6
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int LINE_CLKS     = 1364,
    parameter int REFRESH_START = 536,
    parameter int REFRESH_CLKS  = 40,
    parameter int FAST_LEN      = 6,
    parameter int NORMAL_LEN    = 8,
    parameter int SLOW_LEN      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_internal,
    input  logic              req_write,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              cyc_done,
    output logic              refresh_stall,
    output logic              line_start
);
    logic [LEN_W-1:0] cyc_len;
    logic             speed_hit;
    logic             fast_en;
    logic             stall;

    bct_region_decode #(
        .FAST_LEN   (FAST_LEN),
        .NORMAL_LEN (NORMAL_LEN),
        .SLOW_LEN   (SLOW_LEN)
    ) i_decode (
        .addr          (req_addr),
        .internal      (req_internal),
        .fast_en       (fast_en),
        .len           (cyc_len),
        .speed_reg_hit (speed_hit)
    );

    bct_line_timer #(
        .LINE_CLKS     (LINE_CLKS),
        .REFRESH_START (REFRESH_START),
        .REFRESH_CLKS  (REFRESH_CLKS)
    ) i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .line_start (line_start)
    );

    bct_cycle_engine i_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_internal  (req_internal),
        .req_write     (req_write),
        .wdata_bit     (req_wdata[0]),
        .speed_reg_hit (speed_hit),
        .len           (cyc_len),
        .stall         (stall),
        .ready         (req_ready),
        .done          (cyc_done),
        .fast_en       (fast_en)
    );

    assign refresh_stall = stall;
endmodule

// File: tb/test_bus_cycle_timer.sv
`timescale 1ns/1ps
module test_bus_cycle_timer;
    localparam int LINE  = 1364;
    localparam int RS    = 536;
    localparam int RC    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_internal = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, cyc_done, refresh_stall, line_start;

    int checks = 0;
    int fails  = 0;
    int nedge  = 0;
    int mon_fail_prints = 0;
    bit model_fast = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_timer i_bus_cycle_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_internal(req_internal), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .cyc_done(cyc_done),
        .refresh_stall(refresh_stall), .line_start(line_start)
    );

    always @(posedge clk) if (rst_n) nedge <= nedge + 1;

    function automatic int model_pos();
        return nedge % LINE;
    endfunction

    function automatic bit model_stall();
        int p = model_pos();
        return (p >= RS) && (p < RS + RC);
    endfunction

    function automatic int ref_len(input logic [23:0] a, input bit intl, input bit fast);
        int bank = int'(a[23:16]);
        int pg   = int'(a[15:8]);
        if (intl) return 6;
        if (bank >= 'hC0) return fast ? 6 : 8;
        if (bank >= 'h40 && bank <= 'h7F) return 8;
        if (pg >= 'h80) return (bank >= 'h80) ? (fast ? 6 : 8) : 8;
        if (pg == 'h40 || pg == 'h41) return 12;
        if (pg >= 'h20 && pg <= 'h5F) return 6;
        return 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // continuous line / refresh monitor, R8 and R9
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (refresh_stall !== model_stall() || line_start !== (model_pos() == 0)) begin
                fails++;
                if (mon_fail_prints < 10) begin
                    mon_fail_prints++;
                    $display("FAIL R9/R8 pos=%0d stall actual=%0d expected=%0d start actual=%0d",
                             model_pos(), refresh_stall, model_stall(), line_start);
                end
            end
        end
    end

    // must be called just after a negedge; returns at a negedge with done high
    task automatic run_cycle(input logic [23:0] a, input bit intl, input bit wr,
                             input logic [7:0] wd, output int k, output int st);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_internal = intl; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (wr && !a[22] && a[15:0] == 16'h420D) model_fast = wd[0];
        k = 0; st = 0;
        forever begin
            @(negedge clk);
            if (cyc_done) break;
            if (model_stall()) st++;
            k++;
            if (k > 400) begin
                check(1'b0, "R7 timeout", k, 0);
                break;
            end
        end
    endtask

    task automatic len_check(input logic [23:0] a, input bit intl, input string req);
        int k, st, exp;
        exp = ref_len(a, intl, model_fast);
        run_cycle(a, intl, 1'b0, 8'h00, k, st);
        check(k - st == exp, req, k - st, exp);
        check(req_ready == 1'b1, "R7 ready with done", int'(req_ready), 1);
    endtask

    task automatic write_speed(input logic [23:0] a, input logic [7:0] d);
        int k, st;
        run_cycle(a, 1'b0, 1'b1, d, k, st);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int k, st, per, scount;
        void'($urandom(32'd20160715));
        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
        check(cyc_done == 1'b0, "R11 done", int'(cyc_done), 0);
        check(refresh_stall == 1'b0, "R11 stall", int'(refresh_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && cyc_done == 1'b0, "R11 after release", int'(cyc_done), 0);

        // directed region lengths
        len_check(24'h12_3456, 1'b1, "R1 internal");
        len_check(24'h00_4016, 1'b0, "R2 slow bank00");
        len_check(24'hBF_41FF, 1'b0, "R2 slow bankBF");
        len_check(24'h00_2100, 1'b0, "R3 register low");
        len_check(24'h80_5FFF, 1'b0, "R3 register high");
        len_check(24'h00_1FFF, 1'b0, "R4 low ram");
        len_check(24'h7E_0000, 1'b0, "R4 bank7E");
        len_check(24'h3F_8000, 1'b0, "R4 bank3F rom");
        len_check(24'hC0_0000, 1'b0, "R5 rom hi slow after reset");
        len_check(24'h80_8000, 1'b0, "R5 rom mirror slow");

        // speed bit control, R6
        write_speed(24'h00_420C, 8'h01);
        len_check(24'hC0_1234, 1'b0, "R6 other address ignored");
        write_speed(24'h00_420D, 8'h01);
        len_check(24'hFF_FFFF, 1'b0, "R6 fast after write");
        len_check(24'h80_8000, 1'b0, "R5 fast mirror");
        len_check(24'h00_8000, 1'b0, "R4 bank00 unaffected");
        write_speed(24'h80_420D, 8'hFE);
        len_check(24'hC0_0000, 1'b0, "R6 cleared via mirror bank");

        // line period and refresh count, R8 R9
        while (!line_start) @(negedge clk);
        @(negedge clk);
        per = 1; scount = 0;
        while (!line_start) begin
            if (refresh_stall) scount++;
            per++;
            @(negedge clk);
            if (per > 3000) break;
        end
        check(per == LINE, "R8 line period", per, LINE);
        check(scount == RC, "R9 stall clocks per line", scount, RC);
        check(per - scount == 1324, "R9 cpu clocks per line", per - scount, 1324);

        // cycle fully covered by refresh, R10
        while (!(model_pos() == RS - 3 && req_ready)) @(negedge clk);
        run_cycle(24'h00_4000, 1'b0, 1'b0, 8'h00, k, st);
        check(k == 52, "R10 covered slow cycle total", k, 52);
        check(st == RC, "R10 stalled clocks", st, RC);

        // cycle accepted inside window
        while (!(model_pos() == RS + 5 && req_ready)) @(negedge clk);
        run_cycle(24'h00_0000, 1'b1, 1'b0, 8'h00, k, st);
        check(k == 6 + 34, "R10 accepted in window", k, 40);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [23:0] a;
            bit intl, wr;
            logic [7:0] wd;
            int exp;
            a    = 24'($urandom);
            intl = ($urandom % 8) == 0;
            wr   = ($urandom % 4) == 0;
            wd   = 8'($urandom);
            if (($urandom % 3) == 0) a = {($urandom % 2) ? 8'h80 : 8'h00, 8'(8'h20 + $urandom % 8'h60), a[7:0]};
            if (($urandom % 12) == 0) begin
                a = {($urandom % 2) ? 8'h80 : 8'h3F, 16'h420D};
                wr = 1'b1; intl = 1'b0;
            end
            exp = ref_len(a, intl, model_fast);
            run_cycle(a, intl, wr, wd, k, st);
            check(k - st == exp, "R5/R10 random length", k - st, exp);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule